// File: doc/BRIEF.md
# Serial-Bus Clock Output Enable Controller

This block is a two-wire serial-bus slave that owns the control state of a bank of twelve differential clock output pairs. Software on the bus master can switch each pair on or off and can request a stronger output drive. The slave answers one fixed 7-bit address, 1101001. The write form of the address byte is 0xD2 and the read form is 0xD3. There is no register pointer. Every transfer walks the storage from index 0 upward, one byte per bus byte.

A write transfer begins with two bytes that the slave acknowledges and throws away: a command byte and then a count byte. The bytes after them are data for index 0, index 1 and so on. A read transfer first returns a fixed byte-count value and then the data bytes from index 0 upward. Index 6 holds the enables of pairs 11..8 and the drive-boost flag. Index 7 holds the enables of pairs 7..0. An active-low power-down pin forces every pair off and raises a tri-state indication, whatever the stored enables say.

The bus is seen as sampled SCL and SDA levels. The slave drives SDA only through a pull-down enable, and an open-drain pad outside the block turns that into the wire. The system clock must run at least 16 times faster than the 100 kbit/s bus rate.

Top module: `ddr_oe_slave`

## Requirements
- R1: Only address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address gets no acknowledge, and the bytes that follow until the next START change no state.
- R2: In a write, the first two bytes after the address (command, then count) are acknowledged and never stored.
- R3: Write data bytes go to index 0, 1, 2, ... in order. At index 6, bits 3..0 enable pairs 11..8, bit 5 is the drive boost and bits 7, 6 and 4 are stored as 0. At index 7, bits 7..0 enable pairs 7..0. Enable value 1 means on.
- R4: After reset all twelve pairs are enabled, the boost is off, index 6 reads 0x0F and index 7 reads 0xFF.
- R5: A read returns 0x09 first, then the bytes of index 0, 1, 2, ... in order. Indexes 0 to 5 read 0x00.
- R6: The slave acknowledges every byte it receives after its own address, including bytes to unused indexes.
- R7: A master not-acknowledge after a read byte ends the transfer: SDA stays released until the next START.
- R8: A START or repeated START restarts the index at 0, and a write again skips its command and count bytes.
- R9: While the power-down input is low, all pair enables are 0 and the tri-state output is 1. The stored enables come back when the pin returns high.
- R10: A STOP releases SDA by the following clock cycle.
- R11: Writes to indexes above 7 are acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| pwrdn_n | input | 1 | Active-low power-down |
| pair_oe_o | output | 12 | Enable for each output pair, bit i is pair i |
| drive_boost_o | output | 1 | Enhanced drive strength request |
| outs_hiz_o | output | 1 | 1 puts all clock outputs in high impedance |

## Verification
A wrong byte position shows up right away. The count byte, the 0x00 bytes of the unused indexes or the stored values come back one byte early or late on the next block read, and the pair enables change after the STOP of a write. A wrong bus state shows within the same bit time: an acknowledge is missing or appears where it should not, or SDA is still held low after a not-acknowledge or a STOP, and this is visible at the pull-down output within a few system cycles of the SCL edge. Randomized pairs of index 6 and index 7 values are written and read back through full block transfers, so that every enable bit and the boost bit are seen both set and clear at the ports.

// File: rtl/ddr_oe_pkg.sv
package ddr_oe_pkg;
    localparam int          N_PAIRS    = 12;
    localparam int          POS_W      = 5;
    localparam logic [6:0]  SLV_ADDR   = 7'b1101001;
    localparam logic [7:0]  BYTE_COUNT = 8'h09;
    localparam logic [POS_W-1:0] IDX_HI = 5'd6;
    localparam logic [POS_W-1:0] IDX_LO = 5'd7;
    localparam logic [7:0]  HI_MASK    = 8'h2F;
    localparam logic [7:0]  HI_RESET   = 8'h0F;
    localparam logic [7:0]  LO_RESET   = 8'hFF;
    localparam int          BOOST_BIT  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_WRB, ST_RDB, ST_RDACK
    } bus_st_e;

    typedef struct packed {
        logic [1:0] scl_ff;
        logic [1:0] sda_ff;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    typedef struct packed {
        bus_st_e          st;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [POS_W-1:0] pos;
        logic             rd;
        logic             pull;
        logic             mack;
    } fsm_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } regs_t;
endpackage

// File: rtl/ddr_oe_sync.sv
module ddr_oe_sync
    import ddr_oe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    sync_t d, q;
    logic  scl_s;

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[0], scl_i};
        d.sda_ff = {q.sda_ff[0], sda_i};
        d.scl_p  = q.scl_ff[1];
        d.sda_p  = q.sda_ff[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_ff[1];
    assign sda_s     = q.sda_ff[1];
    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_evt = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_evt  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/ddr_oe_fsm.sv
module ddr_oe_fsm
    import ddr_oe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [7:0]       rd_data,
    output logic [POS_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull
);
    localparam logic [POS_W-1:0] POS_MAX = '1;
    fsm_t       d, q;
    logic [7:0] nxt_byte;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        wr_idx   = q.pos - POS_W'(2);
        wr_data  = q.sh;
        rd_idx   = q.pos - POS_W'(1);
        nxt_byte = (q.pos == '0) ? BYTE_COUNT : rd_data;
        if (start_evt) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.pos  = '0;
            d.pull = 1'b0;
        end else if (stop_evt) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WRB: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == SLV_ADDR) begin
                                d.st   = ST_ACK;
                                d.pull = 1'b1;
                                d.rd   = q.sh[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st   = ST_ACK;
                            d.pull = 1'b1;
                            wr_en  = (q.pos >= POS_W'(2));
                            if (q.pos != POS_MAX) d.pos = q.pos + POS_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st   = ST_RDB;
                            d.sh   = nxt_byte;
                            d.pull = ~nxt_byte[7];
                            if (q.pos != POS_MAX) d.pos = q.pos + POS_W'(1);
                        end else begin
                            d.st   = ST_WRB;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_RDB: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.st   = ST_RDACK;
                            d.pull = 1'b0;
                            d.mack = 1'b0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        if (sda_s) d.st   = ST_IDLE;
                        else       d.mack = 1'b1;
                    end
                    if (scl_fall && q.mack) begin
                        d.st   = ST_RDB;
                        d.cnt  = '0;
                        d.sh   = nxt_byte;
                        d.pull = ~nxt_byte[7];
                        if (q.pos != POS_MAX) d.pos = q.pos + POS_W'(1);
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, sh: '0, pos: '0,
                           rd: 1'b0, pull: 1'b0, mack: 1'b0};
        else        q <= d;
    end

    assign sda_pull = q.pull;
endmodule

// File: rtl/ddr_oe_regs.sv
module ddr_oe_regs
    import ddr_oe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [POS_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [POS_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic [N_PAIRS-1:0] en_bits,
    output logic               boost
);
    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_en && wr_idx == IDX_HI) d.hi = wr_data & HI_MASK;
        if (wr_en && wr_idx == IDX_LO) d.lo = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{hi: HI_RESET, lo: LO_RESET};
        else        q <= d;
    end

    always_comb begin
        if (rd_idx == IDX_HI)      rd_data = q.hi;
        else if (rd_idx == IDX_LO) rd_data = q.lo;
        else                       rd_data = 8'h00;
    end

    assign en_bits = {q.hi[N_PAIRS-9:0], q.lo};
    assign boost   = q.hi[BOOST_BIT];
endmodule

// File: rtl/ddr_oe_slave.sv
module ddr_oe_slave
    import ddr_oe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic               pwrdn_n,
    output logic [N_PAIRS-1:0] pair_oe_o,
    output logic               drive_boost_o,
    output logic               outs_hiz_o
);
    logic               sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic               wr_en;
    logic [POS_W-1:0]   wr_idx, rd_idx;
    logic [7:0]         wr_data, rd_data;
    logic [N_PAIRS-1:0] en_bits;

    ddr_oe_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    ddr_oe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .sda_pull(sda_pull_o)
    );

    ddr_oe_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .en_bits(en_bits), .boost(drive_boost_o)
    );

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_gate
        assign pair_oe_o[i] = en_bits[i] & pwrdn_n;
    end
    assign outs_hiz_o = ~pwrdn_n;
endmodule

// File: rtl/ddr_oe_slave_chk.sv
module ddr_oe_slave_chk
    import ddr_oe_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pwrdn_n,
    input logic [N_PAIRS-1:0] pair_oe_o,
    input logic               outs_hiz_o,
    input logic               sda_pull_o,
    input logic               stop_evt,
    input logic               wr_en,
    input logic [POS_W-1:0]   wr_idx,
    input logic [N_PAIRS-1:0] en_bits,
    input logic               boost
);
    AST_PD_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |-> (pair_oe_o == '0) && outs_hiz_o); // R9
    AST_PD_PASSES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_n |-> (pair_oe_o == en_bits) && !outs_hiz_o); // R9
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_pull_o); // R10
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_bits)); // R3
    AST_BOOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_HI) |=> $stable(boost)); // R3
    AST_HIGH_IDX_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IDX_LO) |=> $stable(en_bits) && $stable(boost)); // R11
endmodule

bind ddr_oe_slave ddr_oe_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .pair_oe_o(pair_oe_o),
    .outs_hiz_o(outs_hiz_o), .sda_pull_o(sda_pull_o), .stop_evt(stop_evt),
    .wr_en(wr_en), .wr_idx(wr_idx), .en_bits(en_bits), .boost(drive_boost_o)
);

// File: tb/ddr_oe_slave_bench.sv
module ddr_oe_slave_bench;
    localparam int HB = 12;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        scl = 1'b1, m_sda = 1'b1, pwrdn_n = 1'b1;
    logic        sda_pull;
    logic [11:0] pair_oe;
    logic        boost, hiz;
    wire         sda_line = m_sda & ~sda_pull;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  m_hi = 8'h0F, m_lo = 8'hFF;

    always #4 clk = ~clk;

    ddr_oe_slave u_ddr_oe_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .pwrdn_n(pwrdn_n), .pair_oe_o(pair_oe),
        .drive_boost_o(boost), .outs_hiz_o(hiz)
    );

    function automatic logic [11:0] exp_oe(logic [7:0] hi, logic [7:0] lo, logic pd_n);
        return {hi[3:0], lo} & {12{pd_n}};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 1'b0; tick(2); m_sda = 1'b1; tick(HB);
        scl = 1'b1; tick(HB); m_sda = 1'b0; tick(HB); scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick(2); m_sda = 1'b0; tick(HB);
        scl = 1'b1; tick(HB); m_sda = 1'b1; tick(HB);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(HB); scl = 1'b1; tick(HB); scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(HB); scl = 1'b1; tick(HB/2);
        ack = ~sda_line; tick(HB/2); scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(logic m_ack, output logic [7:0] v);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(HB); scl = 1'b1; tick(HB/2); v = {v[6:0], sda_line};
            tick(HB/2); scl = 1'b0; tick(2);
        end
        m_sda = ~m_ack; tick(HB); scl = 1'b1; tick(HB); scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic write_block(logic [7:0] hi, logic [7:0] lo, logic [7:0] extra);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
        send_byte(8'h00, a); chk(a, "R2 command byte ack", a, 1);
        send_byte(8'h00, a); chk(a, "R2 count byte ack", a, 1);
        chk(pair_oe == exp_oe(m_hi, m_lo, 1'b1), "R2 header not stored", pair_oe, exp_oe(m_hi, m_lo, 1'b1));
        for (int i = 0; i < 6; i++) begin
            send_byte(8'($urandom_range(255, 0)), a);
            chk(a, "R6 unused index ack", a, 1);
        end
        send_byte(hi, a); chk(a, "R6 index 6 ack", a, 1);
        send_byte(lo, a); chk(a, "R6 index 7 ack", a, 1);
        send_byte(extra, a); chk(a, "R11 index 8 ack", a, 1);
        bus_stop();
        m_hi = hi & 8'h2F; m_lo = lo;
        chk(pair_oe == exp_oe(m_hi, m_lo, 1'b1), "R3 R11 pair enables", pair_oe, exp_oe(m_hi, m_lo, 1'b1));
        chk(boost == m_hi[5], "R3 boost", boost, m_hi[5]);
    endtask

    task automatic read_block();
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
        recv_byte(1'b1, v); chk(v == 8'h09, "R5 count first", v, 8'h09);
        for (int i = 0; i < 6; i++) begin
            recv_byte(1'b1, v); chk(v == 8'h00, "R5 unused reads zero", v, 0);
        end
        recv_byte(1'b1, v); chk(v == m_hi, "R5 index 6 read", v, m_hi);
        recv_byte(1'b0, v); chk(v == m_lo, "R5 index 7 read", v, m_lo);
        chk(!sda_pull, "R7 released after nack", sda_pull, 0);
        tick(HB); scl = 1'b1; tick(HB);
        chk(!sda_pull, "R7 still released", sda_pull, 0);
        scl = 1'b0; tick(2);
        bus_stop();
    endtask

    initial begin
        logic a;
        void'($urandom(32'h5A17));
        tick(5); rst_n = 1'b1; tick(5);
        chk(pair_oe == 12'hFFF, "R4 reset enables", pair_oe, 12'hFFF);
        chk(!boost && !hiz && !sda_pull, "R4 reset flags", {boost, hiz, sda_pull}, 0);
        read_block();

        write_block(8'hF5, 8'h3C, 8'h00);
        read_block();

        bus_start();
        send_byte(8'hA0, a); chk(!a, "R1 foreign address no ack", a, 0);
        send_byte(8'h00, a); send_byte(8'h00, a);
        bus_stop();
        chk(pair_oe == exp_oe(m_hi, m_lo, 1'b1), "R1 foreign no change", pair_oe, exp_oe(m_hi, m_lo, 1'b1));

        bus_start();
        send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
        send_byte(8'h00, a);
        write_block(8'h2A, 8'hC3, 8'hFF);
        chk(pair_oe == exp_oe(8'h2A & 8'h2F, 8'hC3, 1'b1), "R8 repeated start realigns",
            pair_oe, exp_oe(8'h2A & 8'h2F, 8'hC3, 1'b1));

        for (int k = 0; k < 6; k++) begin
            write_block(8'($urandom_range(255, 0)), 8'($urandom_range(255, 0)),
                        8'($urandom_range(255, 0)));
            read_block();
        end

        pwrdn_n = 1'b0; tick(2);
        chk(pair_oe == 12'h000 && hiz, "R9 power down", {hiz, pair_oe}, 13'h1000);
        pwrdn_n = 1'b1; tick(2);
        chk(pair_oe == exp_oe(m_hi, m_lo, 1'b1) && !hiz, "R9 restore", pair_oe, exp_oe(m_hi, m_lo, 1'b1));

        bus_start();
        send_byte(8'hD2, a);
        bus_stop(); tick(1);
        chk(!sda_pull, "R10 stop releases", sda_pull, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule